// File: doc/BRIEF.md
# Cache Region Activity Vector Generator

This block watches the stream of cache accesses and condenses, for each program phase interval, where in the cache that activity landed. The cache sets are split into a fixed number of contiguous regions, here called super sets. Each super set keeps one saturating access counter. When the interval-end pulse arrives, every counter is compared with a programmable threshold. The comparison gives one bit per super set, and together those bits form the activity vector. The vector is latched and the counters start again from zero.

A scheduler compares these vectors to decide which jobs can share a core with little cache interference. The block also keeps the vector from the interval before the last one. That older vector was the prediction in force for the interval that has just ended, since the prediction for the next interval is simply the most recent vector. Reading both outputs at the same moment shows how well the prediction held.

Top module: `cache_region_activity`

## Requirements
- R1: After a synchronous reset, `act_vec`, `pred_vec` and `vec_vld` are all zero.
- R2: An access with `acc_vld` high is counted by super set `acc_set[SET_W-1 -: log2(NREG)]`, which is the upper bits of the set index, and by no other super set. With the defaults this is `acc_set[9:7]`, and vector bit i belongs to super set i.
- R3: Vector bit i is 1 when the count of super set i is strictly greater than `thresh`. It is 0 when the count is equal to `thresh` or less.
- R4: An access presented in the same cycle as `intv_end` is included in the vector latched on that edge.
- R5: On the clock edge where `intv_end` is sampled high, all counters clear to zero. An interval with no accesses therefore yields an all-zero vector, even when `thresh` is 0.
- R6: Counters are CNT_W (16) bits wide and stay at their maximum value instead of wrapping. With 65540 accesses and `thresh` = 65534, the bit reads 1.
- R7: `vec_vld` is high for exactly the one cycle after each edge on which `intv_end` was high.
- R8: When a new vector is latched, `pred_vec` takes the previous value of `act_vec`. This previous value is the prediction that applied to the interval just completed.
- R9: `act_vec` and `pred_vec` keep their values between interval ends, whatever accesses arrive and however `thresh` changes.
- R10: Thresholds of the size used in practice, such as 1024, work exactly. A count of 1025 sets its bit, and a count of 1024 does not.
- R11: A reset asserted in the middle of an interval discards the counts gathered so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | A cache access occurs this cycle |
| acc_set | input | SET_W | Set index of the access |
| intv_end | input | 1 | Marks the last cycle of the interval |
| thresh | input | CNT_W | Activity threshold, compared with strict greater-than |
| act_vec | output | NREG | Activity vector of the most recent completed interval |
| pred_vec | output | NREG | Prediction that applied to that interval (the vector before it) |
| vec_vld | output | 1 | One-cycle strobe when a new vector is latched |

## Verification
The counts are spread unevenly over several super sets, with some counts on the threshold, some one above it and some one below it. This exposes wrong region decoding and a non-strict comparison in a single vector. An access placed on the interval-end cycle tells whether the last access is included or lost. An empty interval run with a zero threshold tells whether the counters really cleared. A 1024 threshold checks that the comparison holds at full width. A run past 65535 accesses tells saturation apart from wrap-around. The test also changes the threshold, keeps accesses flowing between interval ends and pulses reset in the middle of an interval, to show that the latched outputs hold and that stale counts are dropped.

// File: rtl/cache_region_activity.sv
module cache_region_activity #(
  parameter int SET_W = 10,
  parameter int NREG  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic [SET_W-1:0] acc_set,
  input  logic             intv_end,
  input  logic [CNT_W-1:0] thresh,
  output logic [NREG-1:0]  act_vec,
  output logic [NREG-1:0]  pred_vec,
  output logic             vec_vld
);
  localparam int RW = $clog2(NREG);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [RW-1:0]    reg_sel;
  logic [CNT_W-1:0] cnt [NREG];
  logic [NREG-1:0]  vec_now;

  assign reg_sel = acc_set[SET_W-1 -: RW];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic             hit;
    logic [CNT_W-1:0] nxt;

    assign hit = acc_vld && (reg_sel == RW'(gi));
    assign nxt = (hit && cnt[gi] != CMAX) ? cnt[gi] + 1'b1 : cnt[gi];
    assign vec_now[gi] = nxt > thresh;

    always_ff @(posedge clk) begin
      if (rst || intv_end) cnt[gi] <= '0;
      else                 cnt[gi] <= nxt;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      !$past(intv_end) |-> cnt[gi] >= $past(cnt[gi])); // R6
    AST_CLEAR_AFTER_END: assert property (@(posedge clk) disable iff (rst)
      vec_vld |-> cnt[gi] == '0); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_vec  <= '0;
      pred_vec <= '0;
      vec_vld  <= 1'b0;
    end else begin
      vec_vld <= intv_end;
      if (intv_end) begin
        act_vec  <= vec_now;
        pred_vec <= act_vec;
      end
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !vec_vld |-> $stable(act_vec) && $stable(pred_vec)); // R9
  AST_PRED_PREV: assert property (@(posedge clk) disable iff (rst)
    vec_vld |-> pred_vec == $past(act_vec)); // R8
  AST_MAX_THRESH: assert property (@(posedge clk) disable iff (rst)
    vec_vld && $past(thresh) == CMAX |-> act_vec == '0); // R3
endmodule

// File: tb/sim_cache_region_activity.sv
module sim_cache_region_activity;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_vld = 1'b0;
  logic [9:0] acc_set = '0;
  logic       intv_end = 1'b0;
  logic [15:0] thresh = '0;
  logic [7:0] act_vec, pred_vec;
  logic       vec_vld;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  cache_region_activity u0 (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_set(acc_set),
    .intv_end(intv_end), .thresh(thresh),
    .act_vec(act_vec), .pred_vec(pred_vec), .vec_vld(vec_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic hits(input int r, input int n);
    for (int k = 0; k < n; k++) begin
      acc_vld = 1'b1;
      acc_set = {r[2:0], k[6:0]};
      @(negedge clk);
    end
    acc_vld = 1'b0;
  endtask

  task automatic end_iv(input logic [15:0] thr, input bit with_acc, input int r);
    thresh = thr;
    intv_end = 1'b1;
    if (with_acc) begin
      acc_vld = 1'b1;
      acc_set = {r[2:0], 7'h55};
    end
    @(negedge clk);
    intv_end = 1'b0;
    acc_vld = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    do_reset();
    check("R1 act_vec", 32'(act_vec), 0);
    check("R1 pred_vec", 32'(pred_vec), 0);
    check("R1 vec_vld", 32'(vec_vld), 0);
  endtask

  task automatic t_map();
    hits(0, 4); hits(3, 3); hits(6, 5); hits(7, 4);
    end_iv(16'd3, 0, 0);
    check("R2/R3 vector", 32'(act_vec), 32'h0000_00C1);
    check("R7 vec_vld high", 32'(vec_vld), 1);
    check("R8 pred first", 32'(pred_vec), 0);
    @(negedge clk);
    check("R7 vec_vld one cycle", 32'(vec_vld), 0);
  endtask

  task automatic t_edge();
    hits(4, 2);
    end_iv(16'd2, 1, 4);
    check("R4 same-cycle access", 32'(act_vec), 32'h10);
    check("R8 pred is prior vector", 32'(pred_vec), 32'hC1);
  endtask

  task automatic t_empty();
    @(negedge clk);
    end_iv(16'd0, 0, 0);
    check("R5 empty interval", 32'(act_vec), 0);
    check("R8 pred after empty", 32'(pred_vec), 32'h10);
  endtask

  task automatic t_hold();
    hits(1, 10);
    thresh = 16'd0;
    hits(1, 5);
    thresh = 16'hFFFF;
    check("R9 act held", 32'(act_vec), 0);
    check("R9 pred held", 32'(pred_vec), 32'h10);
    check("R9 no strobe", 32'(vec_vld), 0);
    end_iv(16'd14, 0, 0);
    check("R3 count 15 over 14", 32'(act_vec), 32'h02);
  endtask

  task automatic t_big();
    hits(2, 1025);
    hits(5, 1024);
    end_iv(16'd1024, 0, 0);
    check("R10 threshold 1024", 32'(act_vec), 32'h04);
  endtask

  task automatic t_sat();
    hits(1, 65540);
    end_iv(16'hFFFE, 0, 0);
    check("R6 saturation", 32'(act_vec), 32'h02);
    end_iv(16'd0, 1, 6);
    check("R5 cleared after saturation", 32'(act_vec), 32'h40);
  endtask

  task automatic t_rst();
    hits(3, 5);
    do_reset();
    check("R11 act cleared", 32'(act_vec), 0);
    check("R11 pred cleared", 32'(pred_vec), 0);
    end_iv(16'd0, 0, 0);
    check("R11 counts discarded", 32'(act_vec), 0);
    check("R11 strobe after reset", 32'(vec_vld), 1);
  endtask

  initial begin
    t_reset();
    t_map();
    t_edge();
    t_empty();
    t_hold();
    t_big();
    t_sat();
    t_rst();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule